// File: doc/BRIEF.md
# Accumulator Shift, Rotate and Store Scaler

This unit sits beside a wide accumulator. It moves the accumulator one bit to the left or the right, in place, and the bit that falls off the end always goes into a carry flag. A rotate puts the old carry back in at the far end. A mode input picks the kind of right shift: with the mode set, the sign bit is copied; with it clear, a zero comes in at the top. A repeat count turns one command into a run of single-bit steps, one per clock. A busy flag is high while the run lasts, and the unit ignores new work until the run ends.

A separate combinational path feeds stores to memory. It takes the upper or the lower half of the accumulator and shifts it left by 0 to 7 places before it reaches the data output. The accumulator does not change. For the upper half, the bits that come in from the right are taken from the top of the lower half. For the lower half, zeros come in. A load port writes the accumulator directly, so the unit can be fed by an adder that is not part of this block.

Top module: `acc_shift_unit`

## Requirements
- R1: While rst_n is low, the accumulator is 0, the carry is 1 and busy is 0.
- R2: A load_valid at a clock edge where busy is low writes load_data into the accumulator and leaves the carry as it was. If cmd_valid is high in the same cycle, the command is dropped.
- R3: Op code 0 (shift left) moves bit MSB into the carry and shifts in 0 at bit 0. The sign mode has no effect on it.
- R4: Op code 1 (shift right) with sign_mode high, where the mode is sampled when the command is accepted, moves bit 0 into the carry and keeps bit MSB unchanged.
- R5: Op code 1 with sign_mode low moves bit 0 into the carry and shifts in 0 at bit MSB.
- R6: Op code 2 (rotate left) moves bit MSB into the carry and loads the old carry into bit 0.
- R7: Op code 3 (rotate right) moves bit 0 into the carry and loads the old carry into bit MSB.
- R8: A command accepted with repeat count N applies its step N+1 times on consecutive clock edges, the first at the edge of acceptance. busy is high for the N cycles after acceptance.
- R9: While busy is high, cmd_valid and load_valid are ignored. They change neither the op in progress, nor the step count, nor the accumulator.
- R10: With store_hi = 1, store_data equals accumulator bits [MSB-k : HALF-k] for shift amount k. The bits shifted out at the top are lost, and the bits brought in at the bottom come from the lower half.
- R11: With store_hi = 0, store_data equals the lower half shifted left by k, with zeros in the k lowest bits.
- R12: store_data follows the accumulator, store_hi and store_shift with no clock delay. A store never changes the accumulator or the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Write load_data into the accumulator |
| load_data | input | ACC_W | Value to load |
| cmd_valid | input | 1 | Start a shift or rotate command |
| cmd_op | input | 2 | 0 shift left, 1 shift right, 2 rotate left, 3 rotate right |
| cmd_rpt | input | CNT_W | Extra repetitions (N gives N+1 steps) |
| sign_mode | input | 1 | 1 = arithmetic right shift, 0 = logical |
| store_hi | input | 1 | 1 = store the upper half, 0 = store the lower half |
| store_shift | input | SCALE_W | Store left-scale amount, 0 to 7 |
| acc_out | output | ACC_W | Accumulator value |
| carry_out | output | 1 | Carry flag |
| busy | output | 1 | Repeat steps remain |
| store_data | output | ACC_W/2 | Scaled half-word for storage |

## Verification
The bench uses the default 32-bit accumulator and a 4-bit repeat count. At this size a full run of sixteen rotate steps, each passing through the carry, fits in a short test. So do all eight store scale amounts on both halves, with bit patterns that set the top of the lower half apart from the rest. The narrow count also puts the largest count of 15 within reach, together with commands and loads issued in the middle of a run.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
    typedef enum logic [1:0] {
        OP_SHL = 2'd0,
        OP_SHR = 2'd1,
        OP_ROL = 2'd2,
        OP_ROR = 2'd3
    } shift_op_e;
endpackage

// File: rtl/acc_step_unit.sv
// One single-bit shift or rotate through the carry flag.
module acc_step_unit
    import acc_shift_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             carry_i,
    input  shift_op_e        op_i,
    input  logic             sign_mode_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             carry_o
);
    localparam int MSB = ACC_W - 1;

    always_comb begin
        acc_o   = acc_i;
        carry_o = carry_i;
        unique case (op_i)
            OP_SHL: begin
                carry_o = acc_i[MSB];
                acc_o   = {acc_i[MSB-1:0], 1'b0};
            end
            OP_SHR: begin
                carry_o = acc_i[0];
                acc_o   = {(sign_mode_i & acc_i[MSB]), acc_i[MSB:1]};
            end
            OP_ROL: begin
                carry_o = acc_i[MSB];
                acc_o   = {acc_i[MSB-1:0], carry_i};
            end
            OP_ROR: begin
                carry_o = acc_i[0];
                acc_o   = {carry_i, acc_i[MSB:1]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_store_scaler.sv
// Combinational half-word store path with 0..2^SCALE_W-1 left scaling.
module acc_store_scaler #(
    parameter int ACC_W   = 32,
    parameter int SCALE_W = 3
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic               sel_hi_i,
    input  logic [SCALE_W-1:0] amt_i,
    output logic [ACC_W/2-1:0] data_o
);
    localparam int HALF_W = ACC_W / 2;

    logic [ACC_W-1:0] wide_d;
    logic [ACC_W-1:0] shifted_d;

    always_comb begin
        // The low half is zero-extended so nothing but zeros enters from the right.
        wide_d    = sel_hi_i ? acc_i : {{HALF_W{1'b0}}, acc_i[HALF_W-1:0]};
        shifted_d = wide_d << amt_i;
        data_o    = sel_hi_i ? shifted_d[ACC_W-1:HALF_W] : shifted_d[HALF_W-1:0];
    end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
    import acc_shift_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int CNT_W   = 4,
    parameter int SCALE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_valid,
    input  logic [ACC_W-1:0]   load_data,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [CNT_W-1:0]   cmd_rpt,
    input  logic               sign_mode,
    input  logic               store_hi,
    input  logic [SCALE_W-1:0] store_shift,
    output logic [ACC_W-1:0]   acc_out,
    output logic               carry_out,
    output logic               busy,
    output logic [ACC_W/2-1:0] store_data
);
    localparam int MSB    = ACC_W - 1;
    localparam int HALF_W = ACC_W / 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             carry;
        logic [CNT_W-1:0] rem;
        shift_op_e        op;
        logic             sxm;
    } state_t;

    state_t q, d;

    logic             start_d;
    logic             load_ok_d;
    logic             step_en_d;
    shift_op_e        eff_op_d;
    logic             eff_sxm_d;
    logic [ACC_W-1:0] step_acc_d;
    logic             step_carry_d;

    assign busy = (q.rem != '0);

    acc_step_unit #(.ACC_W(ACC_W)) u_step (
        .acc_i      (q.acc),
        .carry_i    (q.carry),
        .op_i       (eff_op_d),
        .sign_mode_i(eff_sxm_d),
        .acc_o      (step_acc_d),
        .carry_o    (step_carry_d)
    );

    acc_store_scaler #(.ACC_W(ACC_W), .SCALE_W(SCALE_W)) u_store (
        .acc_i   (q.acc),
        .sel_hi_i(store_hi),
        .amt_i   (store_shift),
        .data_o  (store_data)
    );

    always_comb begin
        d         = q;
        load_ok_d = load_valid && !busy;
        start_d   = cmd_valid && !busy && !load_valid;
        step_en_d = start_d || busy;
        eff_op_d  = start_d ? shift_op_e'(cmd_op) : q.op;
        eff_sxm_d = start_d ? sign_mode : q.sxm;

        if (load_ok_d) begin
            d.acc = load_data;
        end else if (step_en_d) begin
            d.acc   = step_acc_d;
            d.carry = step_carry_d;
        end

        if (start_d) begin
            d.rem = cmd_rpt;
            d.op  = eff_op_d;
            d.sxm = eff_sxm_d;
        end else if (busy) begin
            d.rem = q.rem - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.acc   <= '0;
            q.carry <= 1'b1;
            q.rem   <= '0;
            q.op    <= OP_SHL;
            q.sxm   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign acc_out   = q.acc;
    assign carry_out = q.carry;

    // Assertions next to the sequencing and step logic.
    a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (q.rem == $past(q.rem) - CNT_W'(1)));

    a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (q.op == $past(q.op)) && (q.sxm == $past(q.sxm)));

    a_r3_shl_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_d && eff_op_d == OP_SHL) |=>
            (!q.acc[0] && q.carry == $past(q.acc[MSB])));

    a_r4_keep_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_d && eff_op_d == OP_SHR && eff_sxm_d) |=>
            (q.acc[MSB] == $past(q.acc[MSB]) && q.carry == $past(q.acc[0])));

    a_r7_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_d && eff_op_d == OP_ROR) |=>
            (q.acc[MSB] == $past(q.carry) && q.carry == $past(q.acc[0])));

    a_r11_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_hi && store_shift != '0) |-> (store_data[0] == 1'b0));

    a_r10_hi_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (store_hi && store_shift == SCALE_W'(1)) |-> (store_data[0] == q.acc[HALF_W-1]));
endmodule

// File: tb/acc_shift_unit_bench.sv
module acc_shift_unit_bench;
    localparam int ACC_W = 32;
    localparam int CNT_W = 4;
    localparam int SW    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_valid = 1'b0;
    logic [ACC_W-1:0] load_data = '0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic [CNT_W-1:0] cmd_rpt = '0;
    logic             sign_mode = 1'b0;
    logic             store_hi = 1'b0;
    logic [SW-1:0]    store_shift = '0;
    logic [ACC_W-1:0] acc_out;
    logic             carry_out;
    logic             busy;
    logic [15:0]      store_data;

    int vectors = 0;
    int fails   = 0;

    // Reference model state
    logic [31:0] m_acc = 32'h0;
    bit          m_c   = 1'b1;
    int          m_rem = 0;
    int          m_op  = 0;
    bit          m_sx  = 1'b0;

    always #4 clk = ~clk;

    acc_shift_unit #(.ACC_W(ACC_W), .CNT_W(CNT_W), .SCALE_W(SW)) u_acc_shift_unit (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rpt(cmd_rpt), .sign_mode(sign_mode),
        .store_hi(store_hi), .store_shift(store_shift), .acc_out(acc_out),
        .carry_out(carry_out), .busy(busy), .store_data(store_data)
    );

    function automatic logic [15:0] model_store(logic [31:0] a, bit hi, int k);
        logic [31:0] t;
        if (hi) begin
            t = a << k;
            return t[31:16];
        end
        t = {16'h0, a[15:0]} << k;
        return t[15:0];
    endfunction

    task automatic model_edge();
        bit was_busy = (m_rem != 0);
        bit st = cmd_valid && !was_busy && !load_valid;
        int op = st ? int'(cmd_op) : m_op;
        bit sx = st ? sign_mode : m_sx;
        if (load_valid && !was_busy) begin
            m_acc = load_data;
        end else if (st || was_busy) begin
            bit oc = m_c;
            case (op)
                0: begin m_c = m_acc[31]; m_acc = m_acc << 1; end
                1: begin
                    m_c = m_acc[0];
                    if (sx) m_acc = $signed(m_acc) >>> 1;
                    else    m_acc = m_acc >> 1;
                end
                2: begin m_c = m_acc[31]; m_acc = {m_acc[30:0], oc}; end
                default: begin m_c = m_acc[0]; m_acc = {oc, m_acc[31:1]}; end
            endcase
        end
        if (st) begin
            m_rem = int'(cmd_rpt); m_op = op; m_sx = sx;
        end else if (was_busy) begin
            m_rem = m_rem - 1;
        end
    endtask

    task automatic compare(input string tag);
        logic [15:0] es = model_store(m_acc, store_hi, int'(store_shift));
        vectors++;
        if (acc_out !== m_acc || carry_out !== m_c || busy !== (m_rem != 0) || store_data !== es) begin
            fails++;
            $display("FAIL %s: acc=%h c=%b busy=%b st=%h expected acc=%h c=%b busy=%b st=%h",
                     tag, acc_out, carry_out, busy, store_data, m_acc, m_c, (m_rem != 0), es);
        end
    endtask

    // Inputs are driven at the falling edge; one clock is taken, then compared.
    task automatic cyc(input string tag);
        if (rst_n) model_edge();
        @(posedge clk);
        @(negedge clk);
        load_valid = 1'b0;
        cmd_valid  = 1'b0;
        compare(tag);
    endtask

    task automatic do_load(input logic [31:0] v, input string tag);
        load_valid = 1'b1; load_data = v;
        cyc(tag);
    endtask

    task automatic do_cmd(input int op, input int rpt, input bit sx, input string tag);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_rpt = CNT_W'(rpt); sign_mode = sx;
        cyc(tag);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        cyc("R1");

        do_load(32'h8000_0001, "R2");
        do_cmd(0, 0, 1'b1, "R3");          // MSB to carry, zero in, sign mode ignored
        do_cmd(0, 0, 1'b0, "R3");
        do_load(32'h8000_0003, "R2");
        do_cmd(1, 0, 1'b1, "R4");          // arithmetic: sign kept
        do_cmd(1, 0, 1'b1, "R4");
        do_load(32'h8000_0003, "R2");
        do_cmd(1, 0, 1'b0, "R5");
        do_cmd(1, 1, 1'b0, "R5");
        cyc("R5");
        do_load(32'h4000_0002, "R2");
        do_cmd(2, 0, 1'b0, "R6");
        do_cmd(2, 0, 1'b0, "R6");
        do_cmd(2, 0, 1'b0, "R6");
        do_cmd(3, 0, 1'b0, "R7");
        do_cmd(3, 0, 1'b0, "R7");
        do_cmd(3, 0, 1'b0, "R7");

        // Load and command together: load wins, command dropped
        load_valid = 1'b1; load_data = 32'hF00F_1234;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_rpt = '0;
        cyc("R2");
        cyc("R2");

        // Repeat runs, with ignored work during busy
        do_cmd(0, 3, 1'b0, "R8");
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_rpt = 4'd7; cyc("R9");
        load_valid = 1'b1; load_data = 32'hDEAD_BEEF; cyc("R9");
        cyc("R8");
        cyc("R8");
        do_load(32'hC3A5_5A3C, "R2");
        do_cmd(2, 15, 1'b0, "R8");
        for (int i = 0; i < 16; i++) cyc("R8");
        do_cmd(1, 15, 1'b1, "R8");
        for (int i = 0; i < 16; i++) cyc("R4");

        // Store scaling: combinational, no clock between setting inputs and checking
        do_load(32'h9ABC_D5E3, "R2");
        for (int h = 0; h < 2; h++) begin
            for (int k = 0; k < 8; k++) begin
                store_hi = h[0]; store_shift = SW'(k);
                #1;
                compare(h != 0 ? "R10" : "R11");
            end
        end
        do_load(32'h0123_8001, "R2");
        store_hi = 1'b1; store_shift = 3'd7; #1; compare("R12");
        store_hi = 1'b0; #1; compare("R12");
        cyc("R12");                        // store leaves accumulator and carry alone
        store_shift = 3'd3; #1; compare("R11");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule